// File: doc/BRIEF.md
# SD/MMC Card Bring-Up Sequencer

This block is a hardware state machine that takes a freshly powered memory card from its idle state to the transfer state without any software involvement. It drives a command-issue port with a command index, a response kind and a 32-bit argument. The port returns a completion pulse, an error flag and up to 128 bits of response. The sequencer first asks for the slow identification clock and resets the card. It then probes the interface condition and tells SD cards from MMC cards. After that it polls the operating condition until the card reports ready. Finally it reads the identification register, establishes the relative card address, reads the card-specific data register, selects the card and asks for the fast data clock.

The results are the card type, the high-capacity flag, the 16-bit relative address, the 128-bit identification and card-data words, and a done or fail indication. A failure records the code of the step that failed and requests that power and the card clock be removed. A new start pulse in the idle, done or failed state begins the sequence again with all results cleared.

Top module: `card_bringup_fsm`

## Requirements
- R1: After reset the block is idle: `cmd_valid`, `done`, `fail`, `pwr_cut` and `clk_run` are 0. After `start`, the first command is index 0 with kind 0 (no response) and argument 0. Every command is issued with `clk_run`=1 and `clk_fast`=0.
- R2: A command holds `cmd_valid`, `cmd_index`, `cmd_kind` and `cmd_arg` steady until the cycle in which `rsp_done` is 1. Kind codes: 0 none, 1 short, 2 short with busy, 3 short operating-condition, 4 long 136-bit.
- R3: The interface-condition command (index 8, kind 1) carries 0x1AA when any of `volt_mask` bits 23..15 is set, and 0x2AA otherwise. Host capacity (bit 30 of the polling argument) is requested only when this command ends without error and `rsp_data[31:0]` equals its argument.
- R4: The SD probe is index 55 (kind 1, argument 0) followed directly by index 41 (kind 3, argument 0). An error on either command switches to an MMC probe with index 1 (kind 3, argument 0). Success on that probe marks the card as MMC (`is_mmc`=1) and always requests host capacity.
- R5: Each polling round sends index 41 with argument {1'b0, hcs, 6'b0, volt_mask}, preceded by index 55 with argument 0 for SD. For MMC the round is index 1 alone. A round is repeated while `rsp_data[31]` is 0, with exactly POLL_GAP_CYC cycles of `cmd_valid`=0 between rounds.
- R6: `high_cap` takes `rsp_data[30]` of the polling response whose bit 31 is set.
- R7: A busy polling response that arrives when POLL_LIMIT_CYC or more cycles have passed since polling began ends the sequence in failure with step code 7.
- R8: After polling, the commands run in a fixed order. First index 2 (kind 4, argument 0), whose response becomes `cid`. Then index 3 (kind 1), with argument 0x00010000 for MMC, which sets `rca` to 1, or argument 0 for SD, which takes `rca` from `rsp_data[31:16]`. Then index 9 (kind 4), whose response becomes `csd`. Then index 7 (kind 2). Both index 9 and index 7 carry {rca, 16'h0}.
- R9: When index 7 completes without error, `done` goes to 1 with `clk_fast`=1 and `clk_run`=1, and no further command is issued.
- R10: An error on any command other than index 8 and the SD probe pair ends in failure. The failure raises `fail`=1 and `pwr_cut`=1 and drops `clk_run` to 0. No further command is issued, and `fail_step` gives the failing step. Step codes: 1 reset, 5 MMC probe, 6 poll index 55, 7 poll, 9 index 2, 10 index 3, 11 index 9, 12 index 7.
- R11: `start` in the done or failed state restarts from index 0 and clears `done`, `fail` and the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin (or restart) the bring-up sequence |
| volt_mask | input | 24 | Supported operating-voltage window, OCR bit layout |
| cmd_valid | output | 1 | Command on the issue port is valid |
| cmd_index | output | 6 | Command index |
| cmd_kind | output | 3 | Expected response kind (see R2) |
| cmd_arg | output | 32 | Command argument |
| rsp_done | input | 1 | One-cycle completion of the current command |
| rsp_err | input | 1 | Completion was an error or timeout |
| rsp_data | input | 128 | Response; short responses in bits 31:0 |
| clk_run | output | 1 | Card clock requested on |
| clk_fast | output | 1 | 1 = data-rate clock, 0 = identification clock |
| pwr_cut | output | 1 | Request to remove card power |
| done | output | 1 | Card reached the transfer state |
| fail | output | 1 | Sequence aborted |
| fail_step | output | 4 | Step code of the failure (see R10) |
| is_mmc | output | 1 | Card answered as MMC |
| high_cap | output | 1 | Card reported high capacity |
| rca | output | 16 | Relative card address |
| cid | output | 128 | Card identification register |
| csd | output | 128 | Card-specific data register |

## Verification
The assertions take for granted that the command port gives exactly one single-cycle `rsp_done` per command, and only while `cmd_valid` is high. They also rely on `volt_mask` staying constant from `start` until done or fail, since the argument stability check depends on it. The bench's responder raises `rsp_done` only a fixed number of cycles after it has seen a valid command, and it lowers the pulse on the following cycle. The scenarios set `volt_mask` before each start pulse and leave it alone until the sequence ends.

// File: rtl/cardinit_pkg.sv
package cardinit_pkg;

    typedef enum logic [3:0] {
        S_IDLE      = 4'd0,
        S_GO_IDLE   = 4'd1,
        S_IF_COND   = 4'd2,
        S_PROBE_APP = 4'd3,
        S_PROBE_OP  = 4'd4,
        S_PROBE_MMC = 4'd5,
        S_POLL_APP  = 4'd6,
        S_POLL_OP   = 4'd7,
        S_POLL_WAIT = 4'd8,
        S_GET_CID   = 4'd9,
        S_SET_RCA   = 4'd10,
        S_GET_CSD   = 4'd11,
        S_SELECT    = 4'd12,
        S_DONE      = 4'd13,
        S_FAILED    = 4'd14
    } step_e;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_SHORT = 3'd1,
        K_BUSY  = 3'd2,
        K_OCR   = 3'd3,
        K_LONG  = 3'd4
    } rsp_kind_e;

    localparam int OCR_W      = 24;
    localparam int RCA_W      = 16;
    localparam int REG_W      = 128;
    localparam int READY_BIT  = 31;
    localparam int CAP_BIT    = 30;
    localparam int LOW_V_TOP  = 15;

    localparam logic [31:0] IFC_PAT_HI = 32'h0000_01AA;
    localparam logic [31:0] IFC_PAT_LO = 32'h0000_02AA;
    localparam logic [RCA_W-1:0] MMC_RCA = 16'h0001;

    typedef struct packed {
        step_e             step;
        logic              is_mmc;
        logic              hcs;
        logic              high_cap;
        logic [RCA_W-1:0]  rca;
        logic [REG_W-1:0]  cid;
        logic [REG_W-1:0]  csd;
        step_e             fail_at;
    } seq_state_t;

endpackage

// File: rtl/cardinit_cmd_table.sv
module cardinit_cmd_table
    import cardinit_pkg::*;
(
    input  step_e                  step,
    input  logic                   is_mmc,
    input  logic                   hcs,
    input  logic [RCA_W-1:0]       rca,
    input  logic [OCR_W-1:0]       volt_mask,
    output logic                   valid,
    output logic [5:0]             index,
    output rsp_kind_e              kind,
    output logic [31:0]            arg
);
    logic [31:0] rca_arg;
    logic [31:0] ocr_arg;
    logic        high_window;

    assign rca_arg     = {rca, 16'h0000};
    assign ocr_arg     = {1'b0, hcs, {(32-OCR_W-2){1'b0}}, volt_mask};
    assign high_window = |volt_mask[OCR_W-1:LOW_V_TOP];

    always_comb begin
        valid = 1'b1;
        index = 6'd0;
        kind  = K_NONE;
        arg   = '0;
        case (step)
            S_GO_IDLE: begin
                index = 6'd0;
                kind  = K_NONE;
            end
            S_IF_COND: begin
                index = 6'd8;
                kind  = K_SHORT;
                arg   = high_window ? IFC_PAT_HI : IFC_PAT_LO;
            end
            S_PROBE_APP, S_POLL_APP: begin
                index = 6'd55;
                kind  = K_SHORT;
            end
            S_PROBE_OP: begin
                index = 6'd41;
                kind  = K_OCR;
            end
            S_PROBE_MMC: begin
                index = 6'd1;
                kind  = K_OCR;
            end
            S_POLL_OP: begin
                index = is_mmc ? 6'd1 : 6'd41;
                kind  = K_OCR;
                arg   = ocr_arg;
            end
            S_GET_CID: begin
                index = 6'd2;
                kind  = K_LONG;
            end
            S_SET_RCA: begin
                index = 6'd3;
                kind  = K_SHORT;
                arg   = is_mmc ? {MMC_RCA, 16'h0000} : 32'h0;
            end
            S_GET_CSD: begin
                index = 6'd9;
                kind  = K_LONG;
                arg   = rca_arg;
            end
            S_SELECT: begin
                index = 6'd7;
                kind  = K_BUSY;
                arg   = rca_arg;
            end
            default: valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/cardinit_poll_timer.sv
module cardinit_poll_timer #(
    parameter int GAP_CYC   = 250_000,
    parameter int LIMIT_CYC = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gap_run,
    input  logic loop_run,
    output logic gap_done,
    output logic expired
);
    localparam int GW = $clog2(GAP_CYC + 1);
    localparam int LW = $clog2(LIMIT_CYC + 1);

    logic [GW-1:0] gap_d, gap_q;
    logic [LW-1:0] age_d, age_q;

    assign gap_done = (gap_q == GW'(GAP_CYC - 1));
    assign expired  = (age_q >= LW'(LIMIT_CYC));

    always_comb begin
        gap_d = '0;
        age_d = '0;
        if (gap_run)
            gap_d = gap_done ? gap_q : gap_q + GW'(1);
        if (loop_run)
            age_d = expired ? age_q : age_q + LW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
            age_q <= '0;
        end else begin
            gap_q <= gap_d;
            age_q <= age_d;
        end
    end
endmodule

// File: rtl/card_bringup_fsm.sv
module card_bringup_fsm
    import cardinit_pkg::*;
#(
    parameter int POLL_GAP_CYC   = 250_000,
    parameter int POLL_LIMIT_CYC = 50_000_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [23:0]         volt_mask,
    output logic                cmd_valid,
    output logic [5:0]          cmd_index,
    output logic [2:0]          cmd_kind,
    output logic [31:0]         cmd_arg,
    input  logic                rsp_done,
    input  logic                rsp_err,
    input  logic [127:0]        rsp_data,
    output logic                clk_run,
    output logic                clk_fast,
    output logic                pwr_cut,
    output logic                done,
    output logic                fail,
    output logic [3:0]          fail_step,
    output logic                is_mmc,
    output logic                high_cap,
    output logic [15:0]         rca,
    output logic [127:0]        cid,
    output logic [127:0]        csd
);
    seq_state_t st_d, st_q;
    rsp_kind_e  kind_w;
    logic       gap_done, expired, gap_run, loop_run;

    cardinit_cmd_table u_table (
        .step      (st_q.step),
        .is_mmc    (st_q.is_mmc),
        .hcs       (st_q.hcs),
        .rca       (st_q.rca),
        .volt_mask (volt_mask),
        .valid     (cmd_valid),
        .index     (cmd_index),
        .kind      (kind_w),
        .arg       (cmd_arg)
    );

    assign gap_run  = (st_q.step == S_POLL_WAIT);
    assign loop_run = (st_q.step == S_POLL_APP) || (st_q.step == S_POLL_OP) ||
                      (st_q.step == S_POLL_WAIT);

    cardinit_poll_timer #(
        .GAP_CYC   (POLL_GAP_CYC),
        .LIMIT_CYC (POLL_LIMIT_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .gap_run  (gap_run),
        .loop_run (loop_run),
        .gap_done (gap_done),
        .expired  (expired)
    );

    always_comb begin
        st_d = st_q;
        case (st_q.step)
            S_IDLE, S_DONE, S_FAILED: begin
                if (start) begin
                    st_d      = '0;
                    st_d.step = S_GO_IDLE;
                end
            end
            S_IF_COND: begin
                if (rsp_done) begin
                    st_d.hcs  = !rsp_err && (rsp_data[31:0] == cmd_arg);
                    st_d.step = S_PROBE_APP;
                end
            end
            S_PROBE_APP: begin
                if (rsp_done)
                    st_d.step = rsp_err ? S_PROBE_MMC : S_PROBE_OP;
            end
            S_PROBE_OP: begin
                if (rsp_done)
                    st_d.step = rsp_err ? S_PROBE_MMC : S_POLL_APP;
            end
            S_POLL_WAIT: begin
                if (gap_done)
                    st_d.step = st_q.is_mmc ? S_POLL_OP : S_POLL_APP;
            end
            default: begin
                if (rsp_done && rsp_err) begin
                    st_d.step    = S_FAILED;
                    st_d.fail_at = st_q.step;
                end else if (rsp_done) begin
                    case (st_q.step)
                        S_GO_IDLE:  st_d.step = S_IF_COND;
                        S_PROBE_MMC: begin
                            st_d.is_mmc = 1'b1;
                            st_d.hcs    = 1'b1;
                            st_d.step   = S_POLL_OP;
                        end
                        S_POLL_APP: st_d.step = S_POLL_OP;
                        S_POLL_OP: begin
                            if (rsp_data[READY_BIT]) begin
                                st_d.high_cap = rsp_data[CAP_BIT];
                                st_d.step     = S_GET_CID;
                            end else if (expired) begin
                                st_d.step    = S_FAILED;
                                st_d.fail_at = S_POLL_OP;
                            end else begin
                                st_d.step = S_POLL_WAIT;
                            end
                        end
                        S_GET_CID: begin
                            st_d.cid  = rsp_data;
                            st_d.step = S_SET_RCA;
                        end
                        S_SET_RCA: begin
                            st_d.rca  = st_q.is_mmc ? MMC_RCA : rsp_data[31:16];
                            st_d.step = S_GET_CSD;
                        end
                        S_GET_CSD: begin
                            st_d.csd  = rsp_data;
                            st_d.step = S_SELECT;
                        end
                        S_SELECT:   st_d.step = S_DONE;
                        default:    st_d.step = S_IDLE;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cmd_kind  = kind_w;
    assign done      = (st_q.step == S_DONE);
    assign fail      = (st_q.step == S_FAILED);
    assign clk_run   = (st_q.step != S_IDLE) && (st_q.step != S_FAILED);
    assign clk_fast  = done;
    assign pwr_cut   = fail;
    assign fail_step = st_q.fail_at;
    assign is_mmc    = st_q.is_mmc;
    assign high_cap  = st_q.high_cap;
    assign rca       = st_q.rca;
    assign cid       = st_q.cid;
    assign csd       = st_q.csd;
endmodule

module card_bringup_fsm_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [5:0]  cmd_index,
    input logic [2:0]  cmd_kind,
    input logic [31:0] cmd_arg,
    input logic        rsp_done,
    input logic        rsp_err,
    input logic        clk_run,
    input logic        clk_fast,
    input logic        pwr_cut,
    input logic        done,
    input logic        fail,
    input logic        is_mmc,
    input logic [15:0] rca
);
    a_r1_slow_clock_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> clk_run && !clk_fast);

    a_r2_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !rsp_done |=> cmd_valid && $stable(cmd_index) &&
                                   $stable(cmd_kind) && $stable(cmd_arg));

    a_r8_rca_in_arg: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_index == 6'd9 || cmd_index == 6'd7) |-> cmd_arg == {rca, 16'h0000});

    a_r8_mmc_fixed_rca: assert property (@(posedge clk) disable iff (!rst_n)
        done && is_mmc |-> rca == 16'h0001);

    a_r9_done_after_select: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(cmd_valid && cmd_index == 6'd7 && rsp_done && !rsp_err));

    a_r9_done_fast_clock: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> clk_fast && clk_run && !cmd_valid);

    a_r10_fail_powers_down: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> pwr_cut && !clk_run && !cmd_valid);

    a_r10_done_fail_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));
endmodule

bind card_bringup_fsm card_bringup_fsm_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_index (cmd_index),
    .cmd_kind  (cmd_kind),
    .cmd_arg   (cmd_arg),
    .rsp_done  (rsp_done),
    .rsp_err   (rsp_err),
    .clk_run   (clk_run),
    .clk_fast  (clk_fast),
    .pwr_cut   (pwr_cut),
    .done      (done),
    .fail      (fail),
    .is_mmc    (is_mmc),
    .rca       (rca)
);

// File: tb/card_bringup_fsm_test.sv
module card_bringup_fsm_test;
    localparam int GAP   = 6;
    localparam int LIMIT = 200;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [23:0]  volt_mask = '0;
    logic         cmd_valid;
    logic [5:0]   cmd_index;
    logic [2:0]   cmd_kind;
    logic [31:0]  cmd_arg;
    logic         rsp_done = 1'b0;
    logic         rsp_err = 1'b0;
    logic [127:0] rsp_data = '0;
    logic         clk_run, clk_fast, pwr_cut, done, fail, is_mmc, high_cap;
    logic [3:0]   fail_step;
    logic [15:0]  rca;
    logic [127:0] cid, csd;

    card_bringup_fsm #(.POLL_GAP_CYC(GAP), .POLL_LIMIT_CYC(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .volt_mask(volt_mask),
        .cmd_valid(cmd_valid), .cmd_index(cmd_index), .cmd_kind(cmd_kind),
        .cmd_arg(cmd_arg), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .rsp_data(rsp_data), .clk_run(clk_run), .clk_fast(clk_fast),
        .pwr_cut(pwr_cut), .done(done), .fail(fail), .fail_step(fail_step),
        .is_mmc(is_mmc), .high_cap(high_cap), .rca(rca), .cid(cid), .csd(csd)
    );

    always #10 clk = ~clk;

    typedef struct {
        int           idx;
        int           kind;
        logic [31:0]  arg;
        logic [127:0] rsp;
        bit           err;
        int           gap;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    auto_busy = 1'b0;
    logic [31:0] auto_arg = '0;
    int    first_poll_cyc = -1;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150_000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual cycle %0d expected end before 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int idx, input int kind, input logic [31:0] arg,
                        input logic [127:0] rsp, input bit err, input int gap);
        item_t it;
        it.idx = idx; it.kind = kind; it.arg = arg;
        it.rsp = rsp; it.err = err; it.gap = gap;
        exp_q.push_back(it);
    endtask

    // Monitor: pops the expected command, compares it, answers it
    initial begin
        item_t it;
        @(negedge clk);
        forever begin
            while (!cmd_valid) @(negedge clk);
            check(clk_run && !clk_fast, "R1", "slow clock during command",
                  {clk_run, clk_fast}, 2'b10);
            if (exp_q.size() == 0) begin
                if (auto_busy) begin
                    check(cmd_index == 6'd1 && cmd_arg == auto_arg, "R7",
                          "timeout poll command", {cmd_index, cmd_arg}, {6'd1, auto_arg});
                    if (first_poll_cyc < 0) first_poll_cyc = cyc;
                    it.rsp = '0; it.err = 1'b0; it.gap = -1;
                end else begin
                    check(1'b0, "R10", "unexpected command", cmd_index, 0);
                    it.rsp = '0; it.err = 1'b1; it.gap = -1;
                end
            end else begin
                it = exp_q.pop_front();
                check(cmd_index == 6'(it.idx) && cmd_kind == 3'(it.kind) && cmd_arg == it.arg,
                      "R2/R3/R4/R5/R8", "command idx/kind/arg",
                      {cmd_index, cmd_kind, cmd_arg}, {6'(it.idx), 3'(it.kind), it.arg});
            end
            repeat (2) @(negedge clk);
            rsp_done = 1'b1; rsp_err = it.err; rsp_data = it.rsp;
            @(negedge clk);
            rsp_done = 1'b0; rsp_err = 1'b0;
            if (it.gap >= 0) begin
                int g;
                g = 0;
                while (!cmd_valid && g < 1000) begin
                    @(negedge clk);
                    g = g + 1;
                end
                check(g == it.gap, "R5", "idle cycles between commands", g, it.gap);
            end
        end
    end

    task automatic kick(input logic [23:0] vm);
        volt_mask = vm;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(!done && !fail, "R11", "restart clears done/fail", {done, fail}, 2'b00);
    endtask

    task automatic wait_end;
        int n;
        n = 0;
        while (!(done || fail) && n < 20000) begin
            @(negedge clk);
            n = n + 1;
        end
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R10", "all expected commands issued", exp_q.size(), 0);
    endtask

    localparam logic [127:0] CID_A = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    localparam logic [127:0] CSD_A = 128'h400E_0032_5B59_0000_EDC8_7F80_0A40_4001;
    localparam logic [127:0] CID_B = 128'hA5A5_0000_1111_2222_3333_4444_5555_5A5A;
    localparam logic [127:0] CSD_B = 128'h9000_0000_0000_0000_0000_0000_0000_00C3;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!cmd_valid && !done && !fail && !clk_run && !pwr_cut, "R1", "reset state",
              {cmd_valid, done, fail, clk_run, pwr_cut}, 5'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!cmd_valid && !clk_run, "R1", "idle after reset", {cmd_valid, clk_run}, 2'b00);

        // Scenario A: SD, high capacity, echo matches (R1 R3 R4 R5 R6 R8 R9)
        push(0, 0, 32'h0, '0, 0, 0);
        push(8, 1, 32'h1AA, 128'h1AA, 0, 0);
        push(55, 1, 32'h0, '0, 0, 0);
        push(41, 3, 32'h0, 128'h00FF_8000, 0, 0);
        push(55, 1, 32'h0, '0, 0, 0);
        push(41, 3, 32'h4010_0000, 128'h00FF_8000, 0, GAP);
        push(55, 1, 32'h0, '0, 0, 0);
        push(41, 3, 32'h4010_0000, 128'hC0FF_8000, 0, 0);
        push(2, 4, 32'h0, CID_A, 0, 0);
        push(3, 1, 32'h0, 128'h1234_0500, 0, 0);
        push(9, 4, 32'h1234_0000, CSD_A, 0, 0);
        push(7, 2, 32'h1234_0000, 128'h0900, 0, -1);
        kick(24'h10_0000);
        wait_end();
        check(done && !fail, "R9", "SD done", {done, fail}, 2'b10);
        check(clk_fast && clk_run && !cmd_valid, "R9", "fast clock at done",
              {clk_fast, clk_run, cmd_valid}, 3'b110);
        check(!is_mmc && high_cap, "R6", "SD type/capacity", {is_mmc, high_cap}, 2'b01);
        check(rca == 16'h1234, "R8", "SD rca from response", rca, 16'h1234);
        check(cid == CID_A && csd == CSD_A, "R8", "cid/csd capture", {cid[63:0], csd[63:0]},
              {CID_A[63:0], CSD_A[63:0]});

        // Scenario B: MMC, low window, CMD8 and CMD55 error (R3 R4 R5 R6 R8 R11)
        push(0, 0, 32'h0, '0, 0, 0);
        push(8, 1, 32'h2AA, '0, 1, 0);
        push(55, 1, 32'h0, '0, 1, 0);
        push(1, 3, 32'h0, 128'h00FF_8080, 0, 0);
        push(1, 3, 32'h4000_0080, 128'h00FF_8080, 0, GAP);
        push(1, 3, 32'h4000_0080, 128'h80FF_8080, 0, 0);
        push(2, 4, 32'h0, CID_B, 0, 0);
        push(3, 1, 32'h0001_0000, 128'h0, 0, 0);
        push(9, 4, 32'h0001_0000, CSD_B, 0, 0);
        push(7, 2, 32'h0001_0000, 128'h0, 0, -1);
        kick(24'h00_0080);
        wait_end();
        check(done, "R9", "MMC done", done, 1);
        check(is_mmc && !high_cap, "R4", "MMC type, standard capacity (R6)",
              {is_mmc, high_cap}, 2'b10);
        check(rca == 16'h0001, "R8", "MMC rca fixed at 1", rca, 16'h0001);
        check(cid == CID_B && csd == CSD_B, "R8", "MMC cid/csd", {cid[63:0], csd[63:0]},
              {CID_B[63:0], CSD_B[63:0]});

        // Scenario C: echo mismatch keeps hcs clear; CMD2 fails (R3 R10 R11)
        push(0, 0, 32'h0, '0, 0, 0);
        push(8, 1, 32'h1AA, 128'h0AA, 0, 0);
        push(55, 1, 32'h0, '0, 0, 0);
        push(41, 3, 32'h0, '0, 0, 0);
        push(55, 1, 32'h0, '0, 0, 0);
        push(41, 3, 32'h0030_0000, 128'h8030_0000, 0, 0);
        push(2, 4, 32'h0, '0, 1, -1);
        kick(24'h30_0000);
        wait_end();
        check(fail && !done, "R10", "failure flagged", {fail, done}, 2'b10);
        check(fail_step == 4'd9, "R10", "fail step code for index 2", fail_step, 9);
        check(pwr_cut && !clk_run && !cmd_valid, "R10", "power and clock off",
              {pwr_cut, clk_run, cmd_valid}, 3'b100);
        check(!is_mmc && !high_cap, "R6", "SD standard capacity", {is_mmc, high_cap}, 2'b00);

        // Scenario D: MMC card that never leaves busy (R7)
        push(0, 0, 32'h0, '0, 0, 0);
        push(8, 1, 32'h1AA, 128'h1AA, 0, 0);
        push(55, 1, 32'h0, '0, 0, 0);
        push(41, 3, 32'h0, '0, 1, 0);
        push(1, 3, 32'h0, '0, 0, 0);
        auto_arg = 32'h4010_0000;
        auto_busy = 1'b1;
        kick(24'h10_0000);
        wait_end();
        auto_busy = 1'b0;
        check(fail && fail_step == 4'd7, "R7", "poll timeout step", {fail, fail_step}, {1'b1, 4'd7});
        check((cyc - first_poll_cyc) >= LIMIT && (cyc - first_poll_cyc) <= LIMIT + GAP + 12,
              "R7", "timeout window", cyc - first_poll_cyc, LIMIT);

        // Scenario E: reset command error (R10)
        push(0, 0, 32'h0, '0, 1, -1);
        kick(24'h10_0000);
        wait_end();
        check(fail && fail_step == 4'd1, "R10", "reset-step failure", {fail, fail_step},
              {1'b1, 4'd1});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule